// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps through a microprogram held in its own control memory. A control memory of 256 words, each 64 bits wide, is addressed by an 8-bit microprogram counter. Every cycle the word at the counter is fetched. Its 32-bit control field is captured into a microinstruction register that drives the control outputs. The same word decides where the counter goes next.

Each word carries a 24-bit condition mask and an 8-bit jump target. The mask picks condition inputs. If any picked condition is high, the counter loads the target. Otherwise it counts up by one and wraps from 255 to 0.

The microprogram is written through a simple load port while reset is held. The block then runs from address 0 once reset is released.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high, `ctrl_out` is all zeros. At the sampling point after the first rising edge with `rst` low, `ctrl_out` shows bits 31:0 of the word at address 0.
- R2: Word layout is {mask[63:40], target[39:32], control[31:0]}. `ctrl_out` shows the control field of the word fetched at the previous rising edge, one register stage after the fetch.
- R3: When any condition input picked by the mask is 1 at a rising edge, the counter loads the target field of the word fetched at that edge. A single set mask bit k selects `cond_in[k]`.
- R4: When no picked condition is 1, the counter increments by one.
- R5: A mask of all zeros never branches, whatever the value of `cond_in`.
- R6: When the mask has several bits set, the branch is taken if any of the picked conditions is 1 (OR).
- R7: Incrementing from address 255 yields address 0.
- R8: A load-port write (`ld_we`, `ld_addr`, `ld_data`) updates the control memory only while `rst` is high. A write attempted while `rst` is low leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| cond_in | input | 24 | Condition inputs that the mask selects from |
| ctrl_out | output | 32 | Control field of the current microinstruction |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 8 | Load-port word address |
| ld_data | input | 64 | Load-port word data |

## Verification
The bench tags every control field with its own address, so the output sequence reveals the path of the counter.

A jump is taken on one selected condition and skipped when only unselected conditions are high. A design that ignored the mask would jump in the wrong cases. A design that used AND instead of OR would miss the jump when a multi-bit mask has only one condition high.

A zero mask with every condition high must still count up; a design that branched on a zero mask would leave the straight-line sequence. A jump to 254 is followed through 255 and back to 0, which catches a counter that saturates or widens instead of wrapping.

A write issued to a word just ahead of the counter while running must not appear on the output; an ungated load port would show the new word.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int SEQ_ADDR_W = 8;
    localparam int SEQ_WORD_W = 64;
    localparam int SEQ_CTRL_W = 32;
    localparam int SEQ_COND_W = 24;

    typedef struct packed {
        logic [SEQ_ADDR_W-1:0] upc;
        logic [SEQ_CTRL_W-1:0] uir;
    } seq_state_t;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              load_en,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              wr_ok;

    assign wr_ok = we & load_en;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R8: outside the load window a write request leaves the word untouched
    p_no_run_write_r8: assert property (@(posedge clk) disable iff (load_en)
        we |=> (mem_q[$past(waddr)] === $past(mem_q[waddr])));
endmodule

// File: rtl/useq_next.sv
module useq_next #(
    parameter int ADDR_W = 8,
    parameter int COND_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] mask,
    input  logic [COND_W-1:0] cond,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] upc,
    output logic              take,
    output logic [ADDR_W-1:0] upc_next
);
    logic [COND_W-1:0] hit;
    logic [ADDR_W-1:0] upc_inc;

    genvar gi;
    generate
        for (gi = 0; gi < COND_W; gi++) begin : g_pick
            assign hit[gi] = mask[gi] & cond[gi];
        end
    endgenerate

    assign take     = |hit;
    assign upc_inc  = upc + ADDR_W'(1);
    assign upc_next = take ? target : upc_inc;

    // R5: an empty mask can never select a jump
    p_empty_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !take);
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int ADDR_W = SEQ_ADDR_W,
    parameter int WORD_W = SEQ_WORD_W,
    parameter int CTRL_W = SEQ_CTRL_W,
    parameter int COND_W = SEQ_COND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] cond_in,
    output logic [CTRL_W-1:0] ctrl_out,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data
);
    localparam int TGT_LO  = CTRL_W;
    localparam int MASK_LO = CTRL_W + ADDR_W;

    seq_state_t        st_q, st_d;
    logic [WORD_W-1:0] word;
    logic [COND_W-1:0] f_mask;
    logic [ADDR_W-1:0] f_target;
    logic [CTRL_W-1:0] f_ctrl;
    logic              take;
    logic [ADDR_W-1:0] upc_next;

    useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk    (clk),
        .load_en(rst),
        .we     (ld_we),
        .waddr  (ld_addr),
        .wdata  (ld_data),
        .raddr  (st_q.upc),
        .rdata  (word)
    );

    assign f_mask   = word[MASK_LO +: COND_W];
    assign f_target = word[TGT_LO +: ADDR_W];
    assign f_ctrl   = word[CTRL_W-1:0];

    useq_next #(.ADDR_W(ADDR_W), .COND_W(COND_W)) u_next (
        .clk     (clk),
        .rst     (rst),
        .mask    (f_mask),
        .cond    (cond_in),
        .target  (f_target),
        .upc     (st_q.upc),
        .take    (take),
        .upc_next(upc_next)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.upc = '0;
            st_d.uir = '0;
        end else begin
            st_d.upc = upc_next;
            st_d.uir = f_ctrl;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ctrl_out = st_q.uir;

    // R2: output shows the control field fetched one edge earlier
    p_ctrl_lag_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctrl_out == $past(f_ctrl)));

    // R3: a selected high condition loads the target
    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> (st_q.upc == $past(f_target)));

    // R4 and R7: otherwise count up by one, modulo the store depth
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        !take |=> (st_q.upc == ADDR_W'($past(st_q.upc) + 1)));
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] cond_in = '0;
    logic [31:0] ctrl_out;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [63:0] ld_data = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    useq_sequencer u_dut (
        .clk     (clk),
        .rst     (rst),
        .cond_in (cond_in),
        .ctrl_out(ctrl_out),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    function automatic logic [31:0] tag(input logic [7:0] a);
        return 32'h5EC0_0000 | {24'h0, a};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: ctrl_out=%h expected %h", req, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [23:0] m, input logic [7:0] t,
                       input logic [31:0] c);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_addr = a;
        ld_data = {m, t, c};
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst   = 1'b1;
        ld_we = 1'b0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        ld_we = 1'b0;
        rst   = 1'b0;
    endtask

    task automatic expect_next(input string req, input logic [7:0] a);
        @(negedge clk);
        check(req, ctrl_out, tag(a));
    endtask

    task automatic t_reset();
        enter_reset();
        for (int i = 0; i < 256; i++) put(8'(i), 24'h0, 8'h00, tag(8'(i)));
        @(negedge clk);
        ld_we = 1'b0;
        check("R1 zero during reset", ctrl_out, 32'h0);
        release_reset();
        expect_next("R1 first word after reset", 8'h00);
    endtask

    task automatic t_straight();
        enter_reset();
        put(8'h00, 24'h0, 8'h77, tag(8'h00));
        cond_in = 24'hFF_FFFF;
        release_reset();
        expect_next("R2 word 0", 8'h00);
        expect_next("R5 zero mask steps", 8'h01);
        expect_next("R5 zero mask steps", 8'h02);
        expect_next("R4 increment", 8'h03);
    endtask

    task automatic t_jump();
        enter_reset();
        put(8'h00, 24'h00_0020, 8'h40, tag(8'h00));
        cond_in = 24'h00_0020;
        release_reset();
        expect_next("R3 word 0", 8'h00);
        expect_next("R3 jump target", 8'h40);
        expect_next("R4 after target", 8'h41);
    endtask

    task automatic t_no_jump();
        enter_reset();
        put(8'h00, 24'h00_0020, 8'h40, tag(8'h00));
        cond_in = 24'hFF_FFDF;
        release_reset();
        expect_next("R4 word 0", 8'h00);
        expect_next("R4 unselected conditions ignored", 8'h01);
    endtask

    task automatic t_multi();
        enter_reset();
        put(8'h00, 24'h10_0004, 8'h80, tag(8'h00));
        put(8'h80, 24'h00_0008, 8'h33, tag(8'h80));
        cond_in = 24'h10_0000;
        release_reset();
        expect_next("R6 word 0", 8'h00);
        expect_next("R6 OR of picked conditions", 8'h80);
        expect_next("R4 picked condition low", 8'h81);
    endtask

    task automatic t_wrap();
        enter_reset();
        put(8'h00, 24'h00_0001, 8'hFE, tag(8'h00));
        cond_in = 24'h00_0001;
        release_reset();
        expect_next("R7 word 0", 8'h00);
        expect_next("R7 jump to 254", 8'hFE);
        expect_next("R7 255", 8'hFF);
        expect_next("R7 wrap to 0", 8'h00);
        expect_next("R7 loop again", 8'hFE);
    endtask

    task automatic t_run_write();
        enter_reset();
        put(8'h00, 24'h0, 8'h00, tag(8'h00));
        cond_in = '0;
        release_reset();
        @(negedge clk);
        check("R8 word 0", ctrl_out, tag(8'h00));
        ld_we   = 1'b1;
        ld_addr = 8'h02;
        ld_data = {24'h0, 8'h00, 32'hDEAD_0002};
        @(negedge clk);
        check("R8 word 1", ctrl_out, tag(8'h01));
        ld_we = 1'b0;
        expect_next("R8 write while running ignored", 8'h02);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_straight();
        t_jump();
        t_no_jump();
        t_multi();
        t_wrap();
        t_run_write();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        summary();
    end
endmodule